// File: doc/BRIEF.md
# Energy Accumulation Unit with Conditioning Modes

This block keeps two running energy totals, one for active power and one for reactive power. Each time a sample strobe arrives, one signed active-power sample and one signed reactive-power sample are first conditioned by a small set of mode inputs. The conditioned values are then added into wide signed accumulators. The same conditioned values are also registered as per-sample increments, so a downstream pulse-rate generator works from exactly the numbers that went into the totals.

Active power can be taken as is, clamped to non-negative values, or replaced by its magnitude. Reactive power can be taken as is, replaced by its magnitude, or given a sign that follows the active power: when active power is negative, the reactive sample is negated. Both accumulators saturate at their signed limits instead of wrapping. Each one then raises its own sticky overflow flag. A synchronous clear input empties both totals and both flags.

Top module: `energy_accum_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, the accumulators, increments, `inc_vld` and both overflow flags read zero.
- R2: With all mode inputs low, a sample taken on a clock edge where `smp_vld` is high and `clr` is low adds `p_act` to `e_act` and `p_react` to `e_react` as two's complement values. The same edge loads `inc_act`/`inc_react` with the unchanged samples and raises `inc_vld` for exactly one cycle.
- R3: With `mode_act_abs` high, the magnitude of `p_act` is used. The most negative sample (sign bit set, all other bits zero) becomes the largest positive value 2^(SMP_W-1)-1.
- R4: With `mode_act_pos` high and `mode_act_abs` low, a negative `p_act` (sign bit set) contributes zero and a non-negative one is used unchanged. When both bits are high, magnitude mode wins.
- R5: With `mode_re_abs` high, the magnitude of `p_react` is used, with the most negative sample mapped to 2^(SMP_W-1)-1.
- R6: With `mode_re_follow` high and `mode_re_abs` low, `p_react` is negated (most negative maps to 2^(SMP_W-1)-1) when the sign bit of the raw `p_act` is set, and used unchanged otherwise. When both bits are high, magnitude mode wins.
- R7: The value added to each accumulator equals the increment presented on the same cycle, under every mode.
- R8: A sum above 2^(ACC_W-1)-1 or below -2^(ACC_W-1) holds the accumulator at that limit and sets its overflow flag. The flag stays set until clear or reset. The two channels saturate independently, and a sum that lands exactly on a limit does not set the flag.
- R9: A clock edge with `clr` high zeroes both accumulators and both flags. A sample strobed on that same edge is discarded and does not raise `inc_vld`.
- R10: On edges without `smp_vld`, changes on the sample or mode inputs leave the accumulators unchanged, and `inc_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of totals and flags |
| smp_vld | input | 1 | Sample strobe |
| p_act | input | SMP_W | Signed active-power sample |
| p_react | input | SMP_W | Signed reactive-power sample |
| mode_act_abs | input | 1 | Use magnitude of active power |
| mode_act_pos | input | 1 | Drop negative active power |
| mode_re_abs | input | 1 | Use magnitude of reactive power |
| mode_re_follow | input | 1 | Negate reactive power when active power is negative |
| e_act | output | ACC_W | Signed active energy total |
| e_react | output | ACC_W | Signed reactive energy total |
| inc_act | output | SMP_W | Conditioned active increment |
| inc_react | output | SMP_W | Conditioned reactive increment |
| inc_vld | output | 1 | Increments valid, one cycle per sample |
| ovf_act | output | 1 | Sticky saturation flag, active total |
| ovf_react | output | 1 | Sticky saturation flag, reactive total |

## Verification
A wrong conditioning choice shows up one cycle after the strobe, on the increment outputs. The same wrong value also lands in the total on that edge, so comparing increments with the totals exposes any difference between the two paths. A corrupted accumulator stays wrong for every later sample until a clear, so one bad addition is visible on all following results. A saturation fault appears on the edge that crosses a limit, either as a wrapped total or as a missing flag, and a flag that fails to stick is seen on the next sample.

// File: rtl/eau_pkg.sv
`timescale 1ns/1ps
// eau_pkg: shared defaults and the conditioning selector type for the energy
// accumulation unit. Assumes sample widths well below accumulator widths.
package eau_pkg;
    localparam int unsigned SMP_W_DEF = 24;
    localparam int unsigned ACC_W_DEF = 48;

    // Which conditioning applies to one sample
    typedef enum logic [1:0] {
        CM_PLAIN = 2'd0,
        CM_ALT   = 2'd1,
        CM_ABS   = 2'd2
    } cond_sel_e;
endpackage

// File: rtl/eau_conditioner.sv
`timescale 1ns/1ps
// eau_conditioner: maps one signed sample to the value to accumulate.
// Magnitude mode wins over the alternate mode. The alternate mode is chosen at
// elaboration: FOLLOW_REF=1 negates the sample when ref_neg_i is set (reactive
// sign-follow), FOLLOW_REF=0 zeroes the sample when ref_neg_i is set (active
// positive-only, with ref_neg_i tied to the sample's own sign).
// Assumes: negation of the most negative value saturates to the largest positive.
module eau_conditioner
    import eau_pkg::*;
#(
    parameter int  W          = 24,
    parameter bit  FOLLOW_REF = 1'b0
) (
    input  logic signed [W-1:0] smp_i,
    input  logic                ref_neg_i,
    input  logic                abs_en_i,
    input  logic                alt_en_i,
    output logic signed [W-1:0] cond_o
);
    localparam logic signed [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    cond_sel_e          sel;
    logic signed [W-1:0] neg_sat;
    logic signed [W-1:0] alt_val;

    // Pick the conditioning with magnitude mode first
    always_comb begin
        if (abs_en_i)      sel = CM_ABS;
        else if (alt_en_i) sel = CM_ALT;
        else               sel = CM_PLAIN;
    end

    // Negate without wrapping at the most negative code
    always_comb neg_sat = (smp_i == S_MIN) ? S_MAX : -smp_i;

    generate
        if (FOLLOW_REF) begin : g_follow
            // Sign-follow: flip when the reference is negative
            always_comb alt_val = ref_neg_i ? neg_sat : smp_i;
        end else begin : g_posonly
            // Positive-only: drop negative samples
            always_comb alt_val = ref_neg_i ? '0 : smp_i;
        end
    endgenerate

    // Final value mux
    always_comb begin
        case (sel)
            CM_ABS:  cond_o = smp_i[W-1] ? neg_sat : smp_i;
            CM_ALT:  cond_o = alt_val;
            default: cond_o = smp_i;
        endcase
    end
endmodule

// File: rtl/eau_sat_acc.sv
`timescale 1ns/1ps
// eau_sat_acc: signed saturating accumulator with a sticky overflow flag.
// Adds a sign-extended IN_W-bit increment on add_i. Clear has priority over add.
// Assumes ACC_W > IN_W, so one extra sum bit is enough to detect overflow.
module eau_sat_acc #(
    parameter int IN_W  = 24,
    parameter int ACC_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    add_i,
    input  logic signed [IN_W-1:0]  inc_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic                    ovf_o
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [ACC_W-1:0] A_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] A_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [SUM_W-1:0] sum;
    logic                    hi_over;
    logic                    lo_over;

    // Widened sum and limit detection
    always_comb begin
        sum     = {acc_o[ACC_W-1], acc_o} + {{(SUM_W-IN_W){inc_i[IN_W-1]}}, inc_i};
        hi_over = (sum[SUM_W-1] == 1'b0) && (sum[SUM_W-2] == 1'b1);
        lo_over = (sum[SUM_W-1] == 1'b1) && (sum[SUM_W-2] == 1'b0);
    end

    // Accumulator and sticky flag update
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_o <= '0;
            ovf_o <= 1'b0;
        end else if (add_i) begin
            if (hi_over) begin
                acc_o <= A_MAX;
                ovf_o <= 1'b1;
            end else if (lo_over) begin
                acc_o <= A_MIN;
                ovf_o <= 1'b1;
            end else begin
                acc_o <= sum[ACC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/energy_accum_unit.sv
`timescale 1ns/1ps
// energy_accum_unit: conditions active and reactive power samples by the mode
// inputs, adds them into saturating totals, and registers the conditioned
// increments for a pulse-output stage. Increments and totals update on the
// same edge. Assumes mode inputs are stable while smp_vld is high.
module energy_accum_unit
    import eau_pkg::*;
#(
    parameter int SMP_W = SMP_W_DEF,
    parameter int ACC_W = ACC_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] p_act,
    input  logic signed [SMP_W-1:0] p_react,
    input  logic                    mode_act_abs,
    input  logic                    mode_act_pos,
    input  logic                    mode_re_abs,
    input  logic                    mode_re_follow,
    output logic signed [ACC_W-1:0] e_act,
    output logic signed [ACC_W-1:0] e_react,
    output logic signed [SMP_W-1:0] inc_act,
    output logic signed [SMP_W-1:0] inc_react,
    output logic                    inc_vld,
    output logic                    ovf_act,
    output logic                    ovf_react
);
    logic                    take;
    logic signed [SMP_W-1:0] c_act;
    logic signed [SMP_W-1:0] c_react;

    // A sample counts only when no clear is pending
    always_comb take = smp_vld && !clr;

    eau_conditioner #(.W(SMP_W), .FOLLOW_REF(1'b0)) u_cond_act (
        .smp_i     (p_act),
        .ref_neg_i (p_act[SMP_W-1]),
        .abs_en_i  (mode_act_abs),
        .alt_en_i  (mode_act_pos),
        .cond_o    (c_act)
    );

    eau_conditioner #(.W(SMP_W), .FOLLOW_REF(1'b1)) u_cond_react (
        .smp_i     (p_react),
        .ref_neg_i (p_act[SMP_W-1]),
        .abs_en_i  (mode_re_abs),
        .alt_en_i  (mode_re_follow),
        .cond_o    (c_react)
    );

    eau_sat_acc #(.IN_W(SMP_W), .ACC_W(ACC_W)) u_acc_act (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .add_i (take),
        .inc_i (c_act),
        .acc_o (e_act),
        .ovf_o (ovf_act)
    );

    eau_sat_acc #(.IN_W(SMP_W), .ACC_W(ACC_W)) u_acc_react (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .add_i (take),
        .inc_i (c_react),
        .acc_o (e_react),
        .ovf_o (ovf_react)
    );

    // Register the increments alongside the totals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_act   <= '0;
            inc_react <= '0;
            inc_vld   <= 1'b0;
        end else begin
            inc_vld <= take;
            if (take) begin
                inc_act   <= c_act;
                inc_react <= c_react;
            end
        end
    end
endmodule

// File: rtl/eau_checker.sv
`timescale 1ns/1ps
// eau_checker: temporal properties of energy_accum_unit, attached by bind.
// Assumes the synchronous active-low reset of the design.
module eau_checker #(
    parameter int SMP_W = 24,
    parameter int ACC_W = 48
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr,
    input logic                    smp_vld,
    input logic signed [SMP_W-1:0] p_act,
    input logic signed [SMP_W-1:0] p_react,
    input logic                    mode_act_abs,
    input logic                    mode_act_pos,
    input logic                    mode_re_abs,
    input logic                    mode_re_follow,
    input logic signed [ACC_W-1:0] e_act,
    input logic signed [ACC_W-1:0] e_react,
    input logic signed [SMP_W-1:0] inc_act,
    input logic signed [SMP_W-1:0] inc_react,
    input logic                    inc_vld,
    input logic                    ovf_act,
    input logic                    ovf_react
);
    a_r2_inc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        inc_vld |-> $past(smp_vld && !clr));

    a_r3_act_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !clr && mode_act_abs) |=> !inc_act[SMP_W-1]);

    a_r4_act_pos_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !clr && mode_act_pos) |=> !inc_act[SMP_W-1]);

    a_r5_re_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !clr && mode_re_abs) |=> !inc_react[SMP_W-1]);

    a_r6_follow_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !clr && mode_re_follow && !mode_re_abs && !p_act[SMP_W-1])
        |=> (inc_react == $past(p_react)));

    a_r8_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_act && !clr) |=> ovf_act);

    a_r8_react_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_react && !clr) |=> ovf_react);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (e_act == '0 && e_react == '0 && !ovf_act && !ovf_react && !inc_vld));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !clr) |=> ($stable(e_act) && $stable(e_react) && !inc_vld));
endmodule

bind energy_accum_unit eau_checker #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (clr),
    .smp_vld        (smp_vld),
    .p_act          (p_act),
    .p_react        (p_react),
    .mode_act_abs   (mode_act_abs),
    .mode_act_pos   (mode_act_pos),
    .mode_re_abs    (mode_re_abs),
    .mode_re_follow (mode_re_follow),
    .e_act          (e_act),
    .e_react        (e_react),
    .inc_act        (inc_act),
    .inc_react      (inc_react),
    .inc_vld        (inc_vld),
    .ovf_act        (ovf_act),
    .ovf_react      (ovf_react)
);

// File: tb/sim_energy_accum_unit.sv
`timescale 1ns/1ps
// sim_energy_accum_unit: scoreboard bench. The driver computes expected
// increments and totals from the requirements and queues them; the monitor
// pops one item per inc_vld pulse and compares.
module sim_energy_accum_unit;
    localparam int SW = 24;
    localparam int AW = 28;
    localparam longint S_MAX = (64'sd1 <<< (SW-1)) - 1;
    localparam longint S_MIN = -(64'sd1 <<< (SW-1));
    localparam longint A_MAX = (64'sd1 <<< (AW-1)) - 1;
    localparam longint A_MIN = -(64'sd1 <<< (AW-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [SW-1:0] p_act = '0;
    logic signed [SW-1:0] p_react = '0;
    logic mode_act_abs = 1'b0, mode_act_pos = 1'b0, mode_re_abs = 1'b0, mode_re_follow = 1'b0;
    logic signed [AW-1:0] e_act, e_react;
    logic signed [SW-1:0] inc_act, inc_react;
    logic inc_vld, ovf_act, ovf_react;

    always #10 clk = ~clk;

    energy_accum_unit #(.SMP_W(SW), .ACC_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
        .p_act(p_act), .p_react(p_react),
        .mode_act_abs(mode_act_abs), .mode_act_pos(mode_act_pos),
        .mode_re_abs(mode_re_abs), .mode_re_follow(mode_re_follow),
        .e_act(e_act), .e_react(e_react), .inc_act(inc_act), .inc_react(inc_react),
        .inc_vld(inc_vld), .ovf_act(ovf_act), .ovf_react(ovf_react)
    );

    typedef struct {
        longint ia;
        longint ir;
        longint ea;
        longint er;
        bit     oa;
        bit     orr;
        string  tag;
    } exp_t;

    exp_t   q[$];
    int     n_chk = 0;
    int     n_err = 0;
    int     cyc = 0;
    longint m_ea = 0, m_er = 0;
    bit     m_oa = 0, m_or = 0;

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint neg_sat(longint x);
        return (x == S_MIN) ? S_MAX : -x;
    endfunction

    function automatic longint mag(longint x);
        return (x < 0) ? neg_sat(x) : x;
    endfunction

    // Model one saturating addition
    function automatic longint sat_add(longint acc, longint inc, inout bit ovf);
        longint s;
        s = acc + inc;
        if (s > A_MAX) begin ovf = 1; return A_MAX; end
        if (s < A_MIN) begin ovf = 1; return A_MIN; end
        return s;
    endfunction

    // Driver: compute expectation, queue it, strobe one sample
    task automatic send(longint a, longint r, bit aa, bit ap, bit ra, bit rf, string tag);
        exp_t e;
        e.ia = aa ? mag(a) : (ap ? ((a < 0) ? 0 : a) : a);
        e.ir = ra ? mag(r) : ((rf && a < 0) ? neg_sat(r) : r);
        m_ea = sat_add(m_ea, e.ia, m_oa);
        m_er = sat_add(m_er, e.ir, m_or);
        e.ea = m_ea; e.er = m_er; e.oa = m_oa; e.orr = m_or; e.tag = tag;
        q.push_back(e);
        p_act = a[SW-1:0]; p_react = r[SW-1:0];
        mode_act_abs = aa; mode_act_pos = ap; mode_re_abs = ra; mode_re_follow = rf;
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic do_clear(string tag);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_ea = 0; m_er = 0; m_oa = 0; m_or = 0;
        check(e_act == 0 && e_react == 0, tag, longint'(e_act) + longint'(e_react), 0);
        check(!ovf_act && !ovf_react, tag, {ovf_act, ovf_react}, 0);
    endtask

    // Monitor: compare each produced increment set with the queue head
    always @(negedge clk) begin
        if (rst_n && inc_vld) begin
            if (q.size() == 0) begin
                check(0, "R2 unexpected inc_vld", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(longint'(inc_act) == e.ia, {e.tag, " inc_act"}, longint'(inc_act), e.ia);
                check(longint'(inc_react) == e.ir, {e.tag, " inc_react"}, longint'(inc_react), e.ir);
                // R7: totals move by exactly the presented increments
                check(longint'(e_act) == e.ea, {e.tag, " R7 e_act"}, longint'(e_act), e.ea);
                check(longint'(e_react) == e.er, {e.tag, " R7 e_react"}, longint'(e_react), e.er);
                check(ovf_act == e.oa, {e.tag, " ovf_act"}, ovf_act, e.oa);
                check(ovf_react == e.orr, {e.tag, " ovf_react"}, ovf_react, e.orr);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while in reset
        check(e_act == 0 && e_react == 0 && !inc_vld && !ovf_act && !ovf_react,
              "R1 in reset", longint'(e_act), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(e_act == 0 && e_react == 0 && inc_act == 0 && inc_react == 0 && !inc_vld,
              "R1 after release", longint'(e_act), 0);

        // R2: plain signed accumulation
        send(1000, -500, 0, 0, 0, 0, "R2 plain a");
        send(-3000, 7000, 0, 0, 0, 0, "R2 plain b");
        send(S_MAX, S_MIN, 0, 0, 0, 0, "R2 plain limits");
        @(negedge clk);
        check(!inc_vld, "R2 single pulse", inc_vld, 0);

        // R3: active magnitude
        do_clear("R9 clear");
        send(-5000, 0, 1, 0, 0, 0, "R3 abs");
        send(S_MIN, 0, 1, 0, 0, 0, "R3 abs min code");
        send(1234, 0, 1, 0, 0, 0, "R3 abs positive");

        // R4: positive-only and priority
        send(-200, 0, 0, 1, 0, 0, "R4 drop negative");
        send(300, 0, 0, 1, 0, 0, "R4 keep positive");
        send(-400, 0, 1, 1, 0, 0, "R4 abs priority");

        // R5: reactive magnitude
        send(0, -9000, 0, 0, 1, 0, "R5 abs");
        send(0, S_MIN, 0, 0, 1, 0, "R5 abs min code");

        // R6: sign follow
        send(-1, 500, 0, 0, 0, 1, "R6 flip");
        send(10, 500, 0, 0, 0, 1, "R6 pass");
        send(-5, S_MIN, 0, 0, 0, 1, "R6 flip min code");
        send(-5, -700, 0, 0, 1, 1, "R6 abs priority");
        send(S_MIN, 800, 1, 0, 0, 1, "R6 raw sign ref");

        // R10: no strobe, inputs toggle, nothing moves
        @(negedge clk);
        p_act = 24'sd777; p_react = -24'sd777;
        mode_act_abs = 1; mode_act_pos = 1; mode_re_abs = 1; mode_re_follow = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(longint'(e_act) == m_ea && longint'(e_react) == m_er && !inc_vld,
                  "R10 hold", longint'(e_act), m_ea);
        end

        // R9: clear beats a simultaneous sample
        p_act = 24'sd4000; p_react = 24'sd4000;
        clr = 1'b1; smp_vld = 1'b1;
        @(negedge clk);
        clr = 1'b0; smp_vld = 1'b0;
        m_ea = 0; m_er = 0; m_oa = 0; m_or = 0;
        check(e_act == 0 && e_react == 0, "R9 clear wins", longint'(e_act), 0);
        check(!inc_vld, "R9 sample dropped", inc_vld, 0);

        // R8: saturation, exact-limit case, stickiness
        for (int i = 0; i < 16; i++) send(S_MIN, S_MIN, 1, 0, 0, 0, "R8 ramp");
        check(longint'(e_react) == A_MIN && !ovf_react, "R8 exact limit", longint'(e_react), A_MIN);
        send(S_MIN, S_MIN, 1, 0, 0, 0, "R8 saturate");
        send(-1000, 1000, 0, 0, 0, 0, "R8 sticky");
        do_clear("R9 clear flags");
        send(S_MAX, 0, 0, 0, 0, 0, "R8 independent");

        repeat (2) @(negedge clk);
        check(q.size() == 0, "R2 all results seen", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule